// File: doc/BRIEF.md
# Direct-Mapped Read Cache with One-Line Victim Buffer

This block is a small read-only cache for a processor-side requester. It keeps four lines of eight bytes each (32 bytes in all) in a direct-mapped array. Beside the array sits a one-entry victim buffer that holds the most recently displaced line together with its full line address. A request carries a byte address. The block answers one cycle after it accepts the request, giving a 32-bit data word and a source code: hit in the main array, hit in the victim buffer, or miss.

On a victim-buffer hit, the requested line and the line currently in its set trade places in a single clock edge, and the memory side is not used. On a miss in both stores, the valid line in the set moves into the victim buffer and the set is cleared. A line request then goes out on the memory port through a valid/ready handshake. The returned line is written into the set, and the requested word is presented. Only one request is outstanding at any time. The requester sees `reqReady` low while a miss is in progress.

Top module: `vcache_top`

## Requirements
- R1: After reset, all four sets and the victim entry are invalid, `respValid` and `memReqValid` are low and `reqReady` is high, so the first reference to any line reports a miss (source code 3).
- R2: The byte address splits as offset [2:0], set index [4:3] and tag [15:5]. Address bit 2 selects the returned word: 0 gives line bits [31:0] and 1 gives line bits [63:32].
- R3: A request that hits the main array is answered in the cycle after acceptance, with `respValid` high, source code 1 and the addressed word.
- R4: A request that misses the array but matches the victim entry is answered in the cycle after acceptance with source code 2. In the same edge the requested line enters its set and the line that was in that set becomes the victim entry, so later references to each of the two lines hit.
- R5: A request that hits in either store raises no memory request.
- R6: A request that misses both stores moves the valid line of its set into the victim buffer, replacing its old contents. It then raises `memReqValid` with `memReqLine` equal to address bits [15:3], and answers with source code 3.
- R7: `memReqValid` and `memReqLine` hold steady until `memReqReady` is seen. A `memRespValid` pulse before that handshake is ignored. The response appears in the cycle after the `memRespValid` that follows the handshake.
- R8: When the set chosen by a missing request holds no valid line, the victim entry keeps its previous line.
- R9: `reqReady` stays low from the acceptance of a missing request until its response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 16 | Byte address of the request |
| respValid | output | 1 | Response word and source valid this cycle |
| respData | output | 32 | Returned data word |
| respStatus | output | 2 | Source: 1 main hit, 2 victim hit, 3 miss |
| memReqValid | output | 1 | Line fetch request to memory |
| memReqReady | input | 1 | Memory accepts the fetch request |
| memReqLine | output | 13 | Line address being fetched |
| memRespValid | input | 1 | Fetched line present on memRespData |
| memRespData | input | 64 | Fetched line contents |

## Verification
Two moves fall into one edge on a victim hit: the buffered line enters the array, and the line it displaces goes into the buffer. The bench provokes this by alternating between two lines that map to set 0, so every other reference swaps them. It judges each swap by the next reference to each line, which must report a victim hit with the correct word and no memory request. A similar check covers a miss into an empty set. The bench then references the line that was buffered before that miss, and a victim hit shows that the buffer kept its entry.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_VICT = 2'd2,
    SRC_MISS = 2'd3
  } src_e;

  // Strobes from the controller to the datapath for one cycle
  typedef struct packed {
    logic capture;   // latch the accepted request address
    logic swap;      // exchange the victim entry with the indexed set
    logic evict;     // move the indexed valid line to the victim entry, clear the set
    logic fill;      // write the returned line into the stored set
    logic respHit;   // register a word from the array or victim entry
    logic respFill;  // register a word from the returned line
  } strobe_t;

endpackage

// File: rtl/vcache_data.sv
module vcache_data
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int SETS       = 4,
  parameter int WORD_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORDS     = LINE_W / WORD_W,
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int BSEL_W    = $clog2(WORD_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LINE_W-1:0]  memRespData,
  output logic               mainHit,
  output logic               victHit,
  output logic [LADDR_W-1:0] missLine,
  output logic [WORD_W-1:0]  respData
);

  // Lookup fields from the live request, fill fields from the latched one
  logic [ADDR_W-1:0]  reqAddrQ;
  logic [IDX_W-1:0]   lkIdx, fIdx;
  logic [TAG_W-1:0]   lkTag, fTag;
  logic [LADDR_W-1:0] lkLine;
  logic [WSEL_W-1:0]  lkWsel, fWsel;
  logic               unusedBits;

  assign lkIdx    = reqAddr[OFF_W +: IDX_W];
  assign lkTag    = reqAddr[ADDR_W-1 -: TAG_W];
  assign lkLine   = reqAddr[ADDR_W-1 -: LADDR_W];
  assign lkWsel   = reqAddr[BSEL_W +: WSEL_W];
  assign fIdx     = reqAddrQ[OFF_W +: IDX_W];
  assign fTag     = reqAddrQ[ADDR_W-1 -: TAG_W];
  assign fWsel    = reqAddrQ[BSEL_W +: WSEL_W];
  assign missLine = reqAddrQ[ADDR_W-1 -: LADDR_W];
  assign unusedBits = ^{reqAddr[BSEL_W-1:0], reqAddrQ[BSEL_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reqAddrQ <= '0;
    else if (stb.capture) reqAddrQ <= reqAddr;
  end

  // Main array storage
  logic [SETS-1:0]   lineValid;
  logic [TAG_W-1:0]  lineTag  [SETS];
  logic [LINE_W-1:0] lineData [SETS];

  // Victim entry
  logic               victValid;
  logic [LADDR_W-1:0] victLine;
  logic [LINE_W-1:0]  victData;

  // Per-set decode of the lookup and fill indices
  logic [SETS-1:0] selLk, selFill;
  for (genvar g = 0; g < SETS; g++) begin : g_setSel
    assign selLk[g]   = (lkIdx == IDX_W'(g));
    assign selFill[g] = (fIdx  == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lineValid[s] <= 1'b0;
        lineTag[s]   <= '0;
        lineData[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (stb.swap && selLk[s]) begin
          lineValid[s] <= 1'b1;
          lineTag[s]   <= lkTag;
          lineData[s]  <= victData;
        end else if (stb.fill && selFill[s]) begin
          lineValid[s] <= 1'b1;
          lineTag[s]   <= fTag;
          lineData[s]  <= memRespData;
        end else if (stb.evict && selLk[s]) begin
          lineValid[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victValid <= 1'b0;
      victLine  <= '0;
      victData  <= '0;
    end else if (stb.swap) begin
      victValid <= lineValid[lkIdx];
      victLine  <= {lineTag[lkIdx], lkIdx};
      victData  <= lineData[lkIdx];
    end else if (stb.evict && lineValid[lkIdx]) begin
      victValid <= 1'b1;
      victLine  <= {lineTag[lkIdx], lkIdx};
      victData  <= lineData[lkIdx];
    end
  end

  assign mainHit = lineValid[lkIdx] && (lineTag[lkIdx] == lkTag);
  assign victHit = victValid && (victLine == lkLine);

  function automatic logic [WORD_W-1:0] pickWord(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] sel);
    return ln[sel*WORD_W +: WORD_W];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             respData <= '0;
    else if (stb.respHit)  respData <= mainHit ? pickWord(lineData[lkIdx], lkWsel)
                                               : pickWord(victData, lkWsel);
    else if (stb.respFill) respData <= pickWord(memRespData, fWsel);
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(mainHit && victHit)); // R4

  AST_SWAP_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.swap && lineValid[lkIdx]) |=>
      (victValid && victLine == $past({lineTag[lkIdx], lkIdx}))); // R4

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.fill |=> (lineValid[$past(fIdx)] && lineTag[$past(fIdx)] == $past(fTag))); // R6

  AST_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evict && !lineValid[lkIdx]) |=> ($stable(victValid) && $stable(victLine))); // R8

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    mainHit,
  input  logic    victHit,
  output logic    memReqValid,
  input  logic    memReqReady,
  input  logic    memRespValid,
  output strobe_t stb,
  output logic    respValid,
  output src_e    respStatus
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;

  state_e state, nextState;
  src_e   srcNext;

  always_comb begin
    stb       = '0;
    nextState = state;
    srcNext   = SRC_NONE;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          if (mainHit) begin
            stb.respHit = 1'b1;
            srcNext     = SRC_MAIN;
          end else if (victHit) begin
            stb.swap    = 1'b1;
            stb.respHit = 1'b1;
            srcNext     = SRC_VICT;
          end else begin
            stb.evict   = 1'b1;
            nextState   = S_REQ;
          end
        end
      end
      S_REQ: begin
        if (memReqReady) nextState = S_WAIT;
      end
      S_WAIT: begin
        if (memRespValid) begin
          stb.fill     = 1'b1;
          stb.respFill = 1'b1;
          srcNext      = SRC_MISS;
          nextState    = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_REQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      respValid  <= 1'b0;
      respStatus <= SRC_NONE;
    end else begin
      state      <= nextState;
      respValid  <= stb.respHit | stb.respFill;
      respStatus <= srcNext;
    end
  end

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (mainHit || victHit)) |=> !memReqValid); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R7

  AST_BUSY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || state == S_WAIT) |-> !reqReady); // R9

  AST_RESP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respStatus != SRC_NONE)); // R3

endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int SETS       = 4,
  parameter int WORD_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               respValid,
  output logic [WORD_W-1:0]  respData,
  output logic [1:0]         respStatus,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [LADDR_W-1:0] memReqLine,
  input  logic               memRespValid,
  input  logic [LINE_W-1:0]  memRespData
);

  strobe_t stb;
  logic    mainHit, victHit;
  src_e    statusE;

  vcache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .mainHit      (mainHit),
    .victHit      (victHit),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .stb          (stb),
    .respValid    (respValid),
    .respStatus   (statusE)
  );

  vcache_data #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .SETS       (SETS),
    .WORD_W     (WORD_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqAddr     (reqAddr),
    .memRespData (memRespData),
    .mainHit     (mainHit),
    .victHit     (victHit),
    .missLine    (memReqLine),
    .respData    (respData)
  );

  assign respStatus = statusE;

  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqLine)); // R7

endmodule

// File: tb/vcache_top_tb.sv
module vcache_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        respValid;
  logic [31:0] respData;
  logic [1:0]  respStatus;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [12:0] memReqLine;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcache_top u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .reqAddr      (reqAddr),
    .respValid    (respValid),
    .respData     (respData),
    .respStatus   (respStatus),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memReqLine   (memReqLine),
    .memRespValid (memRespValid),
    .memRespData  (memRespData)
  );

  // Source codes: 1 main hit, 2 victim hit, 3 miss
  localparam logic [1:0] ST_M = 2'd1;
  localparam logic [1:0] ST_V = 2'd2;
  localparam logic [1:0] ST_X = 2'd3;

  // Reference stream; set = addr[4:3]
  localparam logic [15:0] VEC_ADDR [NVEC] = '{
    16'h0000, 16'h0004, 16'h0020, 16'h0000, 16'h0024,
    16'h0008, 16'h0000, 16'h000C, 16'h0040, 16'h0020,
    16'h0044, 16'h0010, 16'h0018, 16'h0014, 16'h0024,
    16'h0400, 16'h0004, 16'h0404, 16'hFFF8, 16'h001C };
  localparam logic [1:0] VEC_ST [NVEC] = '{
    ST_X, ST_M, ST_X, ST_V, ST_V,   // R1 cold, R2 word1, R6 conflict, R4 swaps
    ST_X, ST_V, ST_M, ST_X, ST_X,   // R8 empty set keeps victim, R3, R6 overwrite
    ST_V, ST_X, ST_X, ST_M, ST_V,   // R4, R7, R9, R5, R4
    ST_X, ST_X, ST_V, ST_X, ST_V }; // R2 high tag bits, R6, R2, R2, R4
  localparam int VEC_REQ [NVEC] = '{
    1, 2, 6, 4, 4, 8, 8, 3, 6, 6, 4, 7, 9, 5, 4, 2, 6, 2, 2, 4 };

  // Memory model: word1 = {3'b101, line, 16'h1111}, word0 = {3'b010, line, 16'h2222}
  function automatic logic [31:0] expWord(input logic [15:0] a);
    return a[2] ? {3'b101, a[15:3], 16'h1111} : {3'b010, a[15:3], 16'h2222};
  endfunction

  function automatic logic [63:0] lineOf(input logic [12:0] ln);
    return {3'b101, ln, 16'h1111, 3'b010, ln, 16'h2222};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic [15:0] a, input logic [1:0] expSt,
                          input int stall, input int lat, input string req);
    logic [12:0] seenLine;
    bit          heldOk;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    if (expSt != ST_X) begin
      check("R5", "memReqValid on hit", 32'(memReqValid), 32'd0);
    end else begin
      check("R6", "memReqValid on miss", 32'(memReqValid), 32'd1);
      check("R6", "memReqLine", 32'(memReqLine), 32'(a[15:3]));
      seenLine = memReqLine;
      heldOk   = 1'b1;
      for (int k = 0; k < stall; k++) begin
        if (k == 0) begin
          memRespValid = 1'b1;   // early pulse must be ignored
          memRespData  = 64'hDEAD_BEEF_DEAD_BEEF;
        end
        @(negedge clk);
        memRespValid = 1'b0;
        if (!memReqValid || memReqLine != seenLine || respValid) heldOk = 1'b0;
      end
      if (stall > 0) check("R7", "request held, early data ignored", 32'(heldOk), 32'd1);
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      for (int k = 0; k < lat; k++) @(negedge clk);
      check("R9", "reqReady while waiting", 32'(reqReady), 32'd0);
      memRespValid = 1'b1;
      memRespData  = lineOf(a[15:3]);
      @(negedge clk);
      memRespValid = 1'b0;
      memRespData  = ~memRespData;
    end
    check(req, "respValid", 32'(respValid), 32'd1);
    check(req, "respStatus", 32'(respStatus), 32'(expSt));
    check(req, "respData", respData, expWord(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "respValid after reset", 32'(respValid), 32'd0);
    check("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    check("R1", "memReqValid after reset", 32'(memReqValid), 32'd0);

    for (int i = 0; i < NVEC; i++)
      doAccess(VEC_ADDR[i], VEC_ST[i], i % 3, i % 4, $sformatf("R%0d", VEC_REQ[i]));

    // R3: response lasts exactly one cycle
    @(negedge clk);
    check("R3", "respValid drops", 32'(respValid), 32'd0);

    // R1: reset mid-run clears everything, L2 was resident in set 2
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doAccess(16'h0014, ST_X, 1, 0, "R1");
    // R2: same line, other word, now a main hit
    doAccess(16'h0010, ST_M, 0, 0, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule